// File: doc/BRIEF.md
# Block Transmit DMA Engine

This block streams a block of 16-bit words out of a synchronous memory as a sequence of bytes for a byte-wide serial transmitter. Software first programs a start pointer, then writes a length field holding the number of words minus one. That length write is the start trigger. The engine then fetches one word at a time, offers its two bytes on a valid/ready stream, and counts the length field down as each word completes.

The length field can be read back during a transfer and shows how much of the block remains. When the block is finished, the field reads all-ones and stays there until software loads it again. A single-cycle done pulse marks the end of each block. The pointer register can be rewritten at any time, but the value only takes effect when the next block starts.

Top module: `blk_tx_dma`

## Requirements
- R1: After reset, the pointer register (register index 0) and the length register (register index 1) both read 0x0000. `busy_o`, `tx_valid_o`, `mem_req_o` and `done_o` are low.
- R2: The pointer register holds 16 bits and reads back the value last written at register index 0. A write to it never starts a transfer.
- R3: The length register carries a 10-bit field in bits 9:0. Bits 15:10 always read as zero, and write data in those bits has no effect on the length.
- R4: A write to the length register while idle starts a block of length+1 words. Memory reads go to the pointer value first and then advance by 2 for each word. The pointer address wraps modulo 2^16.
- R5: Each word is presented as two bytes, bits 7:0 first and bits 15:8 second, so a block carries 2*(length+1) bytes in memory order.
- R6: The length field decrements by one when the second byte of a word is accepted. While busy, a read returns (length written) minus (words completed).
- R7: When the last word's second byte is accepted, the length field becomes 0x3FF and `busy_o` falls. `done_o` is high for exactly that one following cycle. The field keeps reading 0x3FF until the next length write.
- R8: A pointer write during a transfer does not change the addresses of that transfer. It is read back at once and is used by the next transfer.
- R9: A length write while `busy_o` is high is ignored. The remaining count and the number of bytes sent are unchanged.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` holds its value.
- R11: At most one memory read is outstanding at a time. `mem_rdata_i` must carry the word in the cycle after a `mem_req_o` cycle, and `mem_req_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register index: 0 is the pointer, 1 is the length |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for the register selected by `reg_addr_i` (combinational) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after the request |
| tx_data_o | output | 8 | Byte to the transmitter |
| tx_valid_o | output | 1 | Byte valid |
| tx_ready_i | input | 1 | Transmitter accepts the byte |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-block pulse |

## Verification
The assertions assume that the memory returns data exactly one cycle after each request. They also assume that software never writes the length register in the same cycle that the last byte of a block is accepted. The bench's memory model answers on the falling edge after each request. Its interfering register writes land only a few cycles into blocks of at least nine words. The transmitter's ready input is swept through always-ready, alternating and pseudo-random patterns, so the stall-hold rule is exercised on every byte position.

// File: rtl/blk_tx_dma_pkg.sv
package blk_tx_dma_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_REQ,
    SEQ_WAIT,
    SEQ_SEND
  } seq_state_e;

  localparam int unsigned REG_PTR_IDX = 0;
  localparam int unsigned REG_LEN_IDX = 1;
endpackage

// File: rtl/blk_tx_dma_regs.sv
module blk_tx_dma_regs
  import blk_tx_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned REG_DW = 16,
  parameter int unsigned REG_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  input  logic              word_done_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              start_o,
  output logic              last_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, done_q;
  logic              sel_ptr, sel_len;

  assign sel_ptr = (reg_addr_i == REG_AW'(REG_PTR_IDX));
  assign sel_len = (reg_addr_i == REG_AW'(REG_LEN_IDX));
  assign start_o = reg_wr_i && sel_len && !busy_q;
  assign last_o  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (reg_wr_i && sel_ptr) begin
      ptr_q <= reg_wdata_i[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_o) begin
        cnt_q  <= reg_wdata_i[CNT_W-1:0];  // reserved upper bits dropped
        busy_q <= 1'b1;
      end else if (word_done_i && busy_q) begin
        if (last_o) begin
          cnt_q  <= CNT_MAX;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (sel_ptr) reg_rdata_o[ADDR_W-1:0] = ptr_q;
    else if (sel_len) reg_rdata_o[CNT_W-1:0] = cnt_q;
  end

  assign ptr_o  = ptr_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R7
  wrap_on_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_done_i && busy_q && cnt_q == '0) |=> (cnt_q == CNT_MAX && !busy_q && done_o));
  // R7
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  len_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !word_done_i) |=> $stable(cnt_q));
  // R7
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> done_o);
endmodule

// File: rtl/blk_tx_dma_seq.sv
module blk_tx_dma_seq
  import blk_tx_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              last_i,
  input  logic              word_done_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              load_o
);
  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(DATA_W / 8);

  seq_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start_i) begin
          addr_q <= ptr_i;
          st_q   <= SEQ_REQ;
        end
        SEQ_REQ:  st_q <= SEQ_WAIT;
        SEQ_WAIT: st_q <= SEQ_SEND;
        SEQ_SEND: if (word_done_i) begin
          addr_q <= addr_q + ADDR_STEP;
          st_q   <= last_i ? SEQ_IDLE : SEQ_REQ;
        end
        default:  st_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == SEQ_REQ);
  assign mem_addr_o = addr_q;
  assign load_o     = (st_q == SEQ_WAIT);

  // R11
  one_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R4
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (st_q == SEQ_IDLE));
  // R4
  first_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (mem_req_o && mem_addr_o == $past(ptr_i)));
endmodule

// File: rtl/blk_tx_dma_ser.sv
module blk_tx_dma_ser #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              word_done_o
);
  localparam int unsigned NB = DATA_W / BYTE_W;
  localparam int unsigned IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(NB - 1);

  logic [DATA_W-1:0] word_q;
  logic [IW-1:0]     idx_q;
  logic              vld_q;
  logic [BYTE_W-1:0] lane [NB];
  logic              fire;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = word_q[g*BYTE_W +: BYTE_W];
  end

  assign fire = vld_q && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      idx_q  <= '0;
      vld_q  <= 1'b0;
    end else if (load_i) begin
      word_q <= data_i;
      idx_q  <= '0;
      vld_q  <= 1'b1;
    end else if (fire) begin
      if (idx_q == IDX_LAST) begin
        idx_q <= '0;
        vld_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign tx_data_o   = lane[idx_q];  // low lane first
  assign tx_valid_o  = vld_q;
  assign word_done_o = fire && (idx_q == IDX_LAST);

  // R10
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !tx_ready_i) |=> (vld_q && $stable(tx_data_o)));
  // R5
  no_overwrite_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !vld_q);
endmodule

// File: rtl/blk_tx_dma.sv
module blk_tx_dma #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned REG_DW = 16,
  parameter int unsigned REG_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              busy_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] ptr;
  logic start, last, word_done, load;

  blk_tx_dma_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_DW(REG_DW), .REG_AW(REG_AW)
  ) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_wr_i, .reg_wdata_i, .reg_rdata_o,
    .word_done_i(word_done), .ptr_o(ptr), .start_o(start), .last_o(last),
    .busy_o, .done_o
  );

  blk_tx_dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .start_i(start), .ptr_i(ptr), .last_i(last),
    .word_done_i(word_done), .mem_req_o, .mem_addr_o, .load_o(load)
  );

  blk_tx_dma_ser #(.DATA_W(DATA_W), .BYTE_W(8)) u_ser (
    .clk_i, .rst_ni, .load_i(load), .data_i(mem_rdata_i), .tx_data_o,
    .tx_valid_o, .tx_ready_i, .word_done_o(word_done)
  );
endmodule

// File: tb/blk_tx_dma_tb.sv
module blk_tx_dma_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic        busy, done;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // monitor state
  logic [15:0] cur_base = '0;
  int cur_n = 0, acc = 0, req_n = 0, done_seen = 0, rmode = 0;
  logic [15:0] sw_base = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit prev_stall = 1'b0, prev_req = 1'b0, prev_done = 1'b0;
  logic [7:0] prev_data = '0;

  always #2 clk = ~clk;

  blk_tx_dma u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .busy_o(busy), .done_o(done)
  );

  function automatic logic [15:0] memf(input logic [15:0] a);
    return {a[15:8] + a[7:0], a[7:0] ^ 8'h3C};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // memory model: answers on the falling edge after a request
  initial forever begin
    @(negedge clk);
    if (mem_req) mem_rdata <= memf(mem_addr);
  end

  // ready pattern driver
  initial forever begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: tx_ready = 1'b1;
      1: tx_ready = ~tx_ready;
      default: tx_ready = lfsr[0];
    endcase
  end

  // stream monitor
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (prev_stall)  // R10
        chk(tx_valid && tx_data == prev_data, "R10 stall hold",
            {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, prev_data});
      if (prev_req)  // R11
        chk(!mem_req, "R11 back-to-back request", 32'(mem_req), 32'd0);
      if (prev_done)  // R7
        chk(!done, "R7 done width", 32'(done), 32'd0);
      if (busy && reg_addr == 2'd1 && !reg_wr) begin  // R6 and R3
        logic [15:0] e;
        e = 16'(cur_n - acc / 2);
        chk(reg_rdata == e, "R6 remaining count", 32'(reg_rdata), 32'(e));
      end
      if (mem_req) begin  // R4
        logic [15:0] ea;
        ea = cur_base + 16'(2 * req_n);
        chk(mem_addr == ea, "R4 fetch address", 32'(mem_addr), 32'(ea));
        req_n++;
      end
      if (tx_valid && tx_ready) begin  // R5
        logic [15:0] a, d;
        logic [7:0] eb;
        a = cur_base + 16'(2 * (acc / 2));
        d = memf(a);
        eb = (acc % 2 == 1) ? d[15:8] : d[7:0];
        chk(tx_data == eb, "R5 byte value", 32'(tx_data), 32'(eb));
        acc++;
      end
      if (done) done_seen++;
      prev_stall = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_req   = mem_req;
      prev_done  = done;
    end
  end

  task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk);
    #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic run_xfer(input logic [15:0] base, input bit wr_base,
                          input logic [15:0] lenw, input int mode,
                          input bit interfere, input logic [15:0] new_base);
    int n;
    if (wr_base) begin
      write_reg(2'd0, base);
      sw_base = base;
    end
    n = int'(lenw[9:0]);
    @(negedge clk);
    cur_base = sw_base; cur_n = n; acc = 0; req_n = 0; done_seen = 0; rmode = mode;
    write_reg(2'd1, lenw);
    if (interfere) begin
      repeat (6) @(negedge clk);
      write_reg(2'd0, new_base);   // R8
      sw_base = new_base;
      write_reg(2'd1, 16'h0002);   // R9 ignored while busy
    end
    while (done_seen == 0) @(negedge clk);
    chk(acc == 2 * (n + 1), "R5 byte count", 32'(acc), 32'(2 * (n + 1)));
    chk(req_n == n + 1, "R4 fetch count", 32'(req_n), 32'(n + 1));
    chk(!busy, "R7 busy low at done", 32'(busy), 32'd0);
    reg_addr = 2'd1;
    #1;
    chk(reg_rdata == 16'h03FF, "R7 wrap value", 32'(reg_rdata), 32'h3FF);
    repeat (5) @(negedge clk);
    chk(reg_rdata == 16'h03FF && !tx_valid && !mem_req, "R7 hold after done",
        32'(reg_rdata), 32'h3FF);
    if (interfere) begin
      reg_addr = 2'd0;
      #1;
      chk(reg_rdata == new_base, "R8 pointer readback", 32'(reg_rdata), 32'(new_base));
      reg_addr = 2'd1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reg_addr = 2'd0; #1;
    chk(reg_rdata == 16'h0, "R1 pointer reset", 32'(reg_rdata), 32'd0);
    reg_addr = 2'd1; #1;
    chk(reg_rdata == 16'h0, "R1 length reset", 32'(reg_rdata), 32'd0);
    chk(!busy && !tx_valid && !mem_req && !done, "R1 outputs idle",
        {28'd0, busy, tx_valid, mem_req, done}, 32'd0);

    // R2 readback, no start
    write_reg(2'd0, 16'hA5F0);
    sw_base = 16'hA5F0;
    repeat (3) @(negedge clk);
    reg_addr = 2'd0; #1;
    chk(reg_rdata == 16'hA5F0, "R2 pointer readback", 32'(reg_rdata), 32'hA5F0);
    chk(!busy && !mem_req, "R2 no start on pointer write", 32'(busy), 32'd0);
    reg_addr = 2'd1;

    for (int m = 0; m < 3; m++)
      for (int n = 0; n < 16; n++)
        run_xfer(16'h1000 + 16'(m) * 16'h0400 + 16'(n) * 16'h0040, 1'b1,
                 16'(n), m, 1'b0, 16'h0);

    // R3 reserved bits in write data ignored
    run_xfer(16'h2222, 1'b1, 16'hFC03, 2, 1'b0, 16'h0);
    // R8 and R9 writes while busy
    run_xfer(16'h3000, 1'b1, 16'h0008, 2, 1'b1, 16'h4440);
    run_xfer(16'h0000, 1'b0, 16'h0002, 1, 1'b0, 16'h0);
    // R4 address wrap
    run_xfer(16'hFFFC, 1'b1, 16'h0003, 1, 1'b0, 16'h0);
    // maximum block
    run_xfer(16'h8000, 1'b1, 16'h03FF, 0, 1'b0, 16'h0);
    run_xfer(16'hC000, 1'b1, 16'h03FF, 2, 1'b0, 16'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule